// File: doc/BRIEF.md
# Maskable Interrupt Controller with Qualified Non-Maskable Request

The block collects a parameterised number of external interrupt lines and presents them to a processor as one maskable request with the index of the source being served. It also presents a separate non-maskable request. Each maskable line passes through a two-flop synchronizer. Each line can be set to follow its level or to latch an event on a transition, and the active polarity can be chosen per line. An enable register gates the lines. A fixed priority picks the winner, where the lowest index wins. The winning index is frozen until the processor acknowledges it. The acknowledge clears the served source's pending event.

The non-maskable input is qualified in a hybrid way. A rising edge starts a run, and the request is accepted only if the synchronized input stays high for a programmed number of cycles. A shorter pulse is dropped as spurious. An accepted non-maskable request bypasses the enable register and withholds the maskable request output until its own acknowledge clears it.

Software programs the block through a flat register port: a write strobe, one address, write data and combinational read data. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `irq_hub`

## Requirements
- R1: Bit i of the enable register (address 0) gates source i. A source whose bit is 0 never causes `irq_o`. All enable bits are 0 after reset.
- R2: `nmi_o` is raised regardless of the enable register. While `nmi_o` is high, `irq_o` is held low. A held maskable request reappears once `nmi_o` clears.
- R3: In level mode (bit i of the edge-select register, address 1, equal to 0), the request follows the synchronized line. A line still active after `irq_ack_i` raises the request again one cycle after the acknowledge cycle.
- R4: In edge mode (address 1 bit i = 1), a pending event latches on an active transition. Bit i of the polarity register (address 2) selects the transition: 0 means rising, 1 means falling. In level mode the same bit means active-low. Holding the line steady after the transition, or making the opposite transition, creates no new event.
- R5: The non-maskable request is accepted only if the synchronized `nmi_i` rises and stays high for at least L consecutive sampled cycles, counting the edge cycle. L is the value in the qualification register (address 3), and a value of 0 acts as 1. A shorter pulse is discarded.
- R6: `irq_o` goes high whenever some source is both pending and enabled, and no non-maskable request is pending.
- R7: When several enabled sources are pending, `irq_id_o` reports the lowest index.
- R8: While `irq_o` is held, `irq_id_o` does not change, even if a higher-priority source becomes pending. `irq_ack_i` clears the served edge source's pending event and drops `irq_o` for one cycle. The next winner is presented in the following cycle.
- R9: `nmi_ack_i` clears `nmi_o`.
- R10: A second active transition on an edge source that is already pending merges into the existing event. One acknowledge clears it, and no second request follows.
- R11: After reset, `irq_o` and `nmi_o` are low. Reading addresses 0 to 2 returns 0. Address 3 returns `DEF_QUAL`. Address 4 returns the pending vector, which is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for read and write |
| wr_data_i | input | DATA_W | Register write data |
| rd_data_o | output | DATA_W | Register read data, combinational |
| src_i | input | N_SRC | Asynchronous maskable interrupt lines |
| nmi_i | input | 1 | Asynchronous non-maskable line |
| irq_o | output | 1 | Maskable request to the processor |
| irq_id_o | output | IDX_W | Index of the source being served |
| irq_ack_i | input | 1 | Processor acknowledge of the maskable request |
| nmi_o | output | 1 | Qualified non-maskable request |
| nmi_ack_i | input | 1 | Acknowledge of the non-maskable request |

## Verification
The level tests hold a line active across its acknowledge, which separates a design that follows the line from one that only latches once. The edge tests toggle a line several times while it is pending and drive falling transitions on a falling-edge source, so both event merging and polarity selection are visible. Simultaneous events on several sources, plus a late lower-index event arriving while a winner is held, separate correct priority ordering from correct freezing of the index. Non-maskable pulses one cycle shorter than, and exactly equal to, the programmed length pin down the qualification boundary.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  // register map (addresses decoded by the register block)
  localparam int REG_ENABLE = 0;
  localparam int REG_EDGE   = 1;
  localparam int REG_FALL   = 2;
  localparam int REG_QUAL   = 3;
  localparam int REG_PEND   = 4;
endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int QUAL_W   = 8,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int DEF_QUAL = 4
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [N_SRC-1:0]  pend_i,
  output logic [N_SRC-1:0]  enable_o,
  output logic [N_SRC-1:0]  edge_o,
  output logic [N_SRC-1:0]  fall_o,
  output logic [QUAL_W-1:0] qual_o
);
  logic [N_SRC-1:0]  enable_q;
  logic [N_SRC-1:0]  edge_q;
  logic [N_SRC-1:0]  fall_q;
  logic [QUAL_W-1:0] qual_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      enable_q <= '0;
      edge_q   <= '0;
      fall_q   <= '0;
      qual_q   <= QUAL_W'(DEF_QUAL);
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_W'(REG_ENABLE): enable_q <= wr_data_i[N_SRC-1:0];
        ADDR_W'(REG_EDGE):   edge_q   <= wr_data_i[N_SRC-1:0];
        ADDR_W'(REG_FALL):   fall_q   <= wr_data_i[N_SRC-1:0];
        ADDR_W'(REG_QUAL):   qual_q   <= wr_data_i[QUAL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(REG_ENABLE): rd_data_o = DATA_W'(enable_q);
      ADDR_W'(REG_EDGE):   rd_data_o = DATA_W'(edge_q);
      ADDR_W'(REG_FALL):   rd_data_o = DATA_W'(fall_q);
      ADDR_W'(REG_QUAL):   rd_data_o = DATA_W'(qual_q);
      ADDR_W'(REG_PEND):   rd_data_o = DATA_W'(pend_i);
      default:             rd_data_o = '0;
    endcase
  end

  assign enable_o = enable_q;
  assign edge_o   = edge_q;
  assign fall_o   = fall_q;
  assign qual_o   = qual_q;
endmodule

// File: rtl/irq_hub_src.sv
module irq_hub_src #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [N_SRC-1:0] line_i,
  input  logic [N_SRC-1:0] edge_i,
  input  logic [N_SRC-1:0] fall_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] line_d_q;
  logic [N_SRC-1:0] evt_q;
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    // transition detect on the raw synchronized line, so that changing
    // the polarity bit never manufactures an event
    assign hit[g] = fall_i[g] ? (~line_i[g] & line_d_q[g])
                              : (line_i[g] & ~line_d_q[g]);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        line_d_q[g] <= 1'b0;
        evt_q[g]    <= 1'b0;
      end else begin
        line_d_q[g] <= line_i[g];
        if (!edge_i[g])    evt_q[g] <= 1'b0;
        else if (hit[g])   evt_q[g] <= 1'b1;  // new event beats a clear
        else if (clr_i[g]) evt_q[g] <= 1'b0;
      end
    end

    assign pend_o[g] = edge_i[g] ? evt_q[g] : (line_i[g] ^ fall_i[g]);
  end
endmodule

// File: rtl/irq_hub_arb.sv
module irq_hub_arb #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic             ack_i,
  output logic             hold_o,
  output logic [IDX_W-1:0] id_o,
  output logic [N_SRC-1:0] clr_o
);
  logic [IDX_W-1:0] win;
  logic             hold_q;
  logic [IDX_W-1:0] id_q;

  always_comb begin
    win = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) win = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      hold_q <= 1'b0;
      id_q   <= '0;
    end else if (hold_q) begin
      if (ack_i) hold_q <= 1'b0;
    end else if (|req_i) begin
      hold_q <= 1'b1;
      id_q   <= win;
    end
  end

  assign hold_o = hold_q;
  assign id_o   = id_q;
  assign clr_o  = (hold_q && ack_i) ? (N_SRC'(1) << id_q) : '0;
endmodule

// File: rtl/irq_hub_nmi.sv
module irq_hub_nmi #(
  parameter int QUAL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              line_i,
  input  logic [QUAL_W-1:0] qual_i,
  input  logic              ack_i,
  output logic              acc_o,
  output logic              pend_o
);
  localparam int CW = QUAL_W + 1;

  logic          line_d_q;
  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need;
  logic          rise;
  logic          acc;
  logic          pend_q;

  assign need = (qual_i == '0) ? CW'(1) : CW'(qual_i);
  assign rise = line_i & ~line_d_q;
  assign acc  = (rise && need <= CW'(1)) ||
                (run_q && line_i && (cnt_q + CW'(1) >= need));

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      line_d_q <= 1'b0;
      run_q    <= 1'b0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      line_d_q <= line_i;
      if (rise) begin
        cnt_q <= CW'(1);
        run_q <= (need > CW'(1));
      end else if (run_q) begin
        if (!line_i || acc) run_q <= 1'b0;
        else                cnt_q <= cnt_q + CW'(1);
      end
      if (acc)        pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  assign acc_o  = acc;
  assign pend_o = pend_q;
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int N_SRC    = 8,
  parameter int QUAL_W   = 8,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int DEF_QUAL = 4,
  parameter int IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              nmi_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  irq_id_o,
  input  logic              irq_ack_i,
  output logic              nmi_o,
  input  logic              nmi_ack_i
);
  logic [N_SRC-1:0]  src_s;
  logic              nmi_s;
  logic [N_SRC-1:0]  enable_q;
  logic [N_SRC-1:0]  edge_q;
  logic [N_SRC-1:0]  fall_q;
  logic [QUAL_W-1:0] qual_q;
  logic [N_SRC-1:0]  pend_vec;
  logic [N_SRC-1:0]  req_vec;
  logic [N_SRC-1:0]  clr_vec;
  logic              hold_q;
  logic              nmi_acc;
  logic              nmi_pend;

  irq_hub_sync #(.W(N_SRC + 1)) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .d_i     ({nmi_i, src_i}),
    .q_o     ({nmi_s, src_s})
  );

  irq_hub_regs #(
    .N_SRC(N_SRC), .QUAL_W(QUAL_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .DEF_QUAL(DEF_QUAL)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .pend_i    (pend_vec),
    .enable_o  (enable_q),
    .edge_o    (edge_q),
    .fall_o    (fall_q),
    .qual_o    (qual_q)
  );

  irq_hub_src #(.N_SRC(N_SRC)) u_src (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .line_i  (src_s),
    .edge_i  (edge_q),
    .fall_i  (fall_q),
    .clr_i   (clr_vec),
    .pend_o  (pend_vec)
  );

  assign req_vec = pend_vec & enable_q;

  irq_hub_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .req_i   (req_vec),
    .ack_i   (irq_ack_i),
    .hold_o  (hold_q),
    .id_o    (irq_id_o),
    .clr_o   (clr_vec)
  );

  irq_hub_nmi #(.QUAL_W(QUAL_W)) u_nmi (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .line_i  (nmi_s),
    .qual_i  (qual_q),
    .ack_i   (nmi_ack_i),
    .acc_o   (nmi_acc),
    .pend_o  (nmi_pend)
  );

  assign nmi_o = nmi_pend;
  assign irq_o = hold_q & ~nmi_pend;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             hold_q,
  input logic [IDX_W-1:0] irq_id_o,
  input logic [N_SRC-1:0] req_vec,
  input logic             irq_ack_i,
  input logic             nmi_o,
  input logic             nmi_ack_i,
  input logic             nmi_acc,
  input logic             nmi_s
);
  logic [N_SRC-1:0] below;
  always_comb below = (N_SRC'(1) << irq_id_o) - N_SRC'(1);

  // R1: a newly held source was pending and enabled when captured
  a_r1_captured_enabled: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(hold_q) |-> ((($past(req_vec) >> irq_id_o) & N_SRC'(1)) != '0));

  // R7: no lower-index enabled request existed at capture
  a_r7_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(hold_q) |-> (($past(req_vec) & below) == '0));

  // R8: index frozen while held
  a_r8_id_frozen: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (hold_q && $past(hold_q)) |-> $stable(irq_id_o));

  // R8: acknowledge releases the held request
  a_r8_ack_release: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (hold_q && irq_ack_i) |=> !hold_q);

  // R9: non-maskable acknowledge clears the request
  a_r9_nmi_ack: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (nmi_o && nmi_ack_i && !nmi_acc) |=> !nmi_o);

  // R5: acceptance only while the synchronized input is high
  a_r5_nmi_active: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(nmi_o) |-> $past(nmi_s));
endmodule

bind irq_hub irq_hub_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_n_i   (rst_n_i),
  .hold_q    (hold_q),
  .irq_id_o  (irq_id_o),
  .req_vec   (req_vec),
  .irq_ack_i (irq_ack_i),
  .nmi_o     (nmi_o),
  .nmi_ack_i (nmi_ack_i),
  .nmi_acc   (nmi_acc),
  .nmi_s     (nmi_s)
);

// File: tb/irq_hub_tb.sv
module irq_hub_tb;
  localparam int N_SRC = 8;
  localparam int IDX_W = 3;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int DEF_QUAL = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [N_SRC-1:0]  src = '0;
  logic              nmi = 1'b0;
  logic              irq;
  logic [IDX_W-1:0]  irq_id;
  logic              irq_ack = 1'b0;
  logic              nmi_o;
  logic              nmi_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_hub #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
            .DEF_QUAL(DEF_QUAL)) u_dut (
    .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .src_i(src), .nmi_i(nmi),
    .irq_o(irq), .irq_id_o(irq_id), .irq_ack_i(irq_ack),
    .nmi_o(nmi_o), .nmi_ack_i(nmi_ack)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    addr = ADDR_W'(a); wr_data = DATA_W'(d); wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = ADDR_W'(a);
    #1 d = int'(rd_data);
  endtask

  task automatic ack_irq();
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
  endtask

  task automatic ack_nmi();
    nmi_ack = 1'b1; tick(1); nmi_ack = 1'b0;
  endtask

  task automatic nmi_pulse(input int len);
    nmi = 1'b1; tick(len); nmi = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    check("R11 irq after reset", int'(irq), 0);
    check("R11 nmi after reset", int'(nmi_o), 0);
    for (int a = 0; a < 3; a++) begin
      rd(a, v); check("R11 config reg zero", v, 0);
    end
    rd(3, v); check("R11 qual default", v, DEF_QUAL);
    rd(4, v); check("R11 pending zero", v, 0);
  endtask

  task automatic t_level();
    src[0] = 1'b1; tick(6);
    check("R1 masked level source", int'(irq), 0);
    wr(0, 'h01); tick(3);
    check("R6 enabled source requests", int'(irq), 1);
    check("R6 id of source 0", int'(irq_id), 0);
    ack_irq();
    check("R8 irq drops after ack", int'(irq), 0);
    tick(1);
    check("R3 level still active re-raises", int'(irq), 1);
    src[0] = 1'b0; tick(4);
    ack_irq(); tick(4);
    check("R3 level released no request", int'(irq), 0);
  endtask

  task automatic t_edge_rise();
    int v;
    wr(1, 'h02); wr(0, 'h03);
    src[1] = 1'b1; tick(6);
    check("R4 rising edge requests", int'(irq), 1);
    check("R4 id of source 1", int'(irq_id), 1);
    src[1] = 1'b0; tick(3); src[1] = 1'b1; tick(6);
    ack_irq(); tick(6);
    check("R10 merged event single request", int'(irq), 0);
    rd(4, v); check("R10 pending cleared by one ack", v, 0);
  endtask

  task automatic t_edge_fall();
    src[2] = 1'b1; tick(4);
    wr(1, 'h06); wr(2, 'h04); wr(0, 'h07); tick(4);
    check("R4 idle falling source quiet", int'(irq), 0);
    src[2] = 1'b0; tick(6);
    check("R4 falling edge requests", int'(irq), 1);
    check("R4 id of source 2", int'(irq_id), 2);
    src[2] = 1'b1; ack_irq(); tick(6);
    check("R4 rising on falling source ignored", int'(irq), 0);
  endtask

  task automatic t_prio();
    wr(1, 'h2A); wr(0, 'h2A);
    src[1] = 1'b0; tick(4);
    src[3] = 1'b1; src[5] = 1'b1; tick(6);
    check("R7 lowest of 3 and 5", int'(irq_id), 3);
    src[1] = 1'b1; tick(6);
    check("R8 id held despite source 1", int'(irq_id), 3);
    check("R8 irq still held", int'(irq), 1);
    ack_irq(); tick(1);
    check("R7 source 1 next", int'(irq_id), 1);
    ack_irq(); tick(1);
    check("R7 source 5 last", int'(irq_id), 5);
    ack_irq(); tick(4);
    check("R8 all served", int'(irq), 0);
  endtask

  task automatic t_nmi();
    wr(0, 0); wr(3, 5);
    nmi_pulse(4); tick(8);
    check("R5 short pulse discarded", int'(nmi_o), 0);
    nmi_pulse(5); tick(8);
    check("R5 exact length accepted, R2 mask ignored", int'(nmi_o), 1);
    ack_nmi(); tick(1);
    check("R9 nmi ack clears", int'(nmi_o), 0);
    wr(1, 0); wr(2, 0);
    src = '0; src[0] = 1'b1; wr(0, 'h01); tick(4);
    check("R6 maskable before nmi", int'(irq), 1);
    nmi_pulse(6); tick(8);
    check("R2 nmi pending", int'(nmi_o), 1);
    check("R2 irq withheld by nmi", int'(irq), 0);
    ack_nmi(); tick(1);
    check("R2 irq returns after nmi", int'(irq), 1);
    check("R2 id kept", int'(irq_id), 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_level();
    t_edge_rise();
    t_edge_fall();
    t_prio();
    t_nmi();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule